// File: doc/BRIEF.md
# Single-Byte Serial Peripheral Master

This block is a serial peripheral master that moves one byte at a time and has no FIFO. A processor drives it through a small byte-wide register file. The processor loads an outgoing byte, then sets a start bit. The block then clocks eight bits out on MOSI and samples eight bits from MISO at the same time. When the eighth bit has been sampled, the block latches the received byte, flags it as ready and raises its interrupt. Its busy flag drops one bus clock later.

A mode register sets how the serial clock behaves: its idle level, and which of its two edges samples data. The same register holds the port enable, the bit order and an internal loopback path from the transmitter to the receiver. A divisor register sets the serial clock rate as a fraction of the bus clock. Each completed byte gives one interrupt, and reading the received byte removes it. Chip selects are driven elsewhere.

Top module: `byte_spi_master`

## Requirements
- R1: After reset every register reads 0x00, SCK and MOSI are low, and the interrupt is low.
- R2: The byte offsets are fixed. Offset 0 is mode, 1 is received data, 2 is outgoing data, 3 is control, 4 is status and 6 is divisor. Mode keeps bits 4:0, and bits 7:5 read as 0. Outgoing data and the divisor read back what was written. Control and offset 5 always read 0x00.
- R3: With mode bit 3 (0x08, enable) set, writing 0x01 to control starts one 8-bit exchange. The written byte goes out on MOSI. The byte sampled from MISO appears at the received-data offset.
- R4: Mode bit 2 (0x04) at 0 sends and receives MSB first. At 1 it sends and receives LSB first.
- R5: Mode bit 1 (0x02) sets the SCK idle level: 0 is low and 1 is high. SCK sits at that level whenever no exchange is running. Mode bit 4 (0x10) at 1 samples on the leading SCK edge, and MOSI is valid before the first edge. At 0 it samples on the trailing edge, and MOSI changes on leading edges.
- R6: Each SCK half period is 2×(divisor+1) bus clocks. Busy (status bit 1, 0x02) therefore reads 1 for exactly 32×(divisor+1)+1 consecutive bus clocks from the clock edge that takes the start write.
- R7: Receive-ready (status bit 0, 0x01) sets in the same cycle as the received byte is latched. Busy is still 1 in that cycle and reads 0 in the next.
- R8: The interrupt output equals receive-ready. A read of the received-data offset clears both.
- R9: With mode bit 0 (0x01) set, the receiver takes the MOSI bit stream in place of MISO, so the received byte equals the sent byte in any clock mode.
- R10: While enable is 0, SCK holds its idle level, MOSI is low, and a start write leaves busy and the interrupt at 0.
- R11: A start write while busy is ignored. The exchange in progress keeps its length and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; only affects the received-data offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Byte-complete interrupt, level |

## Verification
Exchanges run against a bench slave model. The model keeps its own phase and bit order, derived from the requirements. Random bytes are sent under random combinations of clock polarity, sample edge, bit order, loopback and small divisors. Mismatched edge handling shows up as a shifted or corrupted byte, in either the slave's captured byte or the master's received byte. Bit-order errors show up as a mirrored byte. Loopback runs drive MISO to a constant, so loopback data can only come from the internal path. Directed cases cover:
- the largest divisor, to check the length formula at its far end;
- a start issued mid-exchange, which must not stretch the busy window;
- a disabled port, where the start must have no visible effect.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_RXD  = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_TXD  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd6;

   // packed so that field order equals mode bits 4..0
   typedef struct packed {
      logic lead_smp;   // 1: sample on leading SCK edge
      logic enable;
      logic lsb_first;
      logic idle_hi;
      logic loop_back;
   } mode_t;

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   // half period of 2*(div+1) cycles: count 0 .. 2*div+1
   assign limit = {div, 1'b1};
   assign tick  = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            lead_smp,
   input  logic            lsb_first,
   input  logic            start,
   input  logic            tick,
   input  logic [BITS-1:0] tx_byte,
   input  logic            din,
   output logic            active,
   output logic            tail,
   output logic            sck_q,
   output logic            mosi_q,
   output logic            done,
   output logic [BITS-1:0] rx_word
);
   localparam int EW = $clog2(2 * BITS);
   localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BITS - 1);

   logic [BITS-1:0] sh, rx, tx_rev, tx_ord, rx_fin, rx_rev;
   logic [EW-1:0]   ecnt;
   logic            leading, last;

   genvar gi;
   generate
      for (gi = 0; gi < BITS; gi++) begin : g_rev
         assign tx_rev[gi] = tx_byte[BITS-1-gi];
         assign rx_rev[gi] = rx_fin[BITS-1-gi];
      end
   endgenerate

   assign tx_ord  = lsb_first ? tx_rev : tx_byte;
   assign leading = !ecnt[0];
   assign last    = (ecnt == LAST_EDGE);
   assign done    = active && tick && last;
   // last edge is trailing: it samples only in trailing-sample mode
   assign rx_fin  = lead_smp ? rx : {rx[BITS-2:0], din};
   assign rx_word = lsb_first ? rx_rev : rx_fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         tail   <= 1'b0;
         sck_q  <= 1'b0;
         mosi_q <= 1'b0;
         ecnt   <= '0;
         sh     <= '0;
         rx     <= '0;
      end else begin
         tail <= 1'b0;
         if (!en) begin
            active <= 1'b0;
            sck_q  <= 1'b0;
            ecnt   <= '0;
         end else if (start && !active) begin
            active <= 1'b1;
            ecnt   <= '0;
            sck_q  <= 1'b0;
            rx     <= '0;
            if (lead_smp) begin
               mosi_q <= tx_ord[BITS-1];
               sh     <= {tx_ord[BITS-2:0], 1'b0};
            end else begin
               sh <= tx_ord;
            end
         end else if (active && tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 1'b1;
            if (leading == lead_smp)
               rx <= {rx[BITS-2:0], din};
            else if (!last) begin
               mosi_q <= sh[BITS-1];
               sh     <= {sh[BITS-2:0], 1'b0};
            end
            if (last) begin
               active <= 1'b0;
               tail   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              done,
   input  logic [7:0]        rx_word,
   input  logic              busy,
   output mode_t             mode,
   output logic [7:0]        txd,
   output logic [DIV_W-1:0]  div,
   output logic              start,
   output logic              rx_ready
);
   logic [7:0] rxd;

   assign start = wr && (addr == OFS_CTRL) && wdata[0] && mode.enable && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= '0;
         txd      <= '0;
         div      <= '0;
         rxd      <= '0;
         rx_ready <= 1'b0;
      end else begin
         if (wr) begin
            case (addr)
               OFS_MODE: mode <= mode_t'(wdata[4:0]);
               OFS_TXD:  txd  <= wdata;
               OFS_DIV:  div  <= wdata[DIV_W-1:0];
               default: ;
            endcase
         end
         if (done) begin
            rxd      <= rx_word;
            rx_ready <= 1'b1;
         end else if (rd && (addr == OFS_RXD)) begin
            rx_ready <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         OFS_MODE: rdata = {3'b000, mode};
         OFS_RXD:  rdata = rxd;
         OFS_TXD:  rdata = txd;
         OFS_STAT: rdata = {6'd0, busy, rx_ready};
         OFS_DIV:  rdata = 8'(div);
         default:  rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master
   import spim_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              irq
);
   initial begin
      assert (DIV_W >= 1 && DIV_W <= 8)
         else $error("DIV_W must be within 1..8");
   end

   mode_t            mode;
   logic [7:0]       txd, rx_word;
   logic [DIV_W-1:0] div;
   logic             start, rx_ready, done, tick;
   logic             active, tail, busy, sck_q, mosi_q, din;

   assign busy = active | tail;
   assign din  = mode.loop_back ? mosi_q : spi_miso;

   spim_regs #(.DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .rdata(reg_rdata), .done(done), .rx_word(rx_word),
      .busy(busy), .mode(mode), .txd(txd), .div(div), .start(start),
      .rx_ready(rx_ready)
   );

   spim_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(active), .div(div), .tick(tick)
   );

   spim_engine #(.BITS(8)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(mode.enable), .lead_smp(mode.lead_smp),
      .lsb_first(mode.lsb_first), .start(start), .tick(tick), .tx_byte(txd),
      .din(din), .active(active), .tail(tail), .sck_q(sck_q),
      .mosi_q(mosi_q), .done(done), .rx_word(rx_word)
   );

   assign spi_sck  = mode.enable ? (sck_q ^ mode.idle_hi) : mode.idle_hi;
   assign spi_mosi = mode.enable & mosi_q;
   assign irq      = rx_ready;
endmodule

// File: rtl/spim_chk.sv
module spim_chk
   import spim_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rx_ready,
   input logic              irq,
   input logic              sck,
   input logic              mosi,
   input logic              en,
   input logic              idle_hi,
   input logic              rd,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rdata
);
   AST_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> busy);                                      // R7
   AST_BUSY_DROPS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |=> !busy);                                     // R7
   AST_IRQ_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_STAT) |-> (rdata[0] == irq));                      // R8
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == OFS_RXD && !busy) |=> !irq);                     // R8
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == idle_hi));                                    // R5
   AST_OFF_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !mosi);                                                 // R10
   AST_OFF_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);                                                 // R10
endmodule

bind byte_spi_master spim_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .rx_ready(rx_ready), .irq(irq),
   .sck(spi_sck), .mosi(spi_mosi), .en(mode.enable), .idle_hi(mode.idle_hi),
   .rd(reg_rd), .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/sim_byte_spi_master.sv
`timescale 1ns/1ps
module sim_byte_spi_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_mosi, irq;
   logic       spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   byte_spi_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
   );

   // slave model
   logic       s_on = 1'b0, s_cpha = 1'b0, s_cpol = 1'b0, s_lsb = 1'b0;
   logic [7:0] s_tx = 8'd0, s_rx = 8'd0;
   int         s_j = 0;

   function automatic logic seq_bit(logic [7:0] b, int j, logic lsb);
      return lsb ? b[j] : b[7-j];
   endfunction

   function automatic logic [7:0] mode_byte(logic cpha, logic lsb, logic cpol,
                                            logic lb);
      return {3'b000, ~cpha, 1'b1, lsb, cpol, lb};
   endfunction

   function automatic int busy_len(int d);
      return 32 * (d + 1) + 1;
   endfunction

   always @(spi_sck) begin
      if (s_on && s_j < 8) begin
         if (spi_sck != s_cpol) begin
            if (!s_cpha) s_rx[s_lsb ? s_j : 7 - s_j] = spi_mosi;
            else         spi_miso = seq_bit(s_tx, s_j, s_lsb);
         end else begin
            if (s_cpha) s_rx[s_lsb ? s_j : 7 - s_j] = spi_mosi;
            s_j = s_j + 1;
            if (!s_cpha && s_j < 8) spi_miso = seq_bit(s_tx, s_j, s_lsb);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // one exchange: R3 R4 R5 R6 R7 R8 R9 R11
   task automatic xfer(input logic cpha, input logic lsb, input logic cpol,
                       input logic lb, input int d, input logic [7:0] tb,
                       input logic [7:0] sb, input logic poke);
      logic [7:0] v;
      int n;
      logic prev_rdy, last_rdy;
      wr(3'd6, 8'(d));
      wr(3'd0, mode_byte(cpha, lsb, cpol, lb));
      wr(3'd2, tb);
      #1 chk("R5 idle level before start", spi_sck, cpol);
      s_cpha = cpha; s_cpol = cpol; s_lsb = lsb; s_tx = sb;
      s_j = 0; s_rx = 8'd0;
      if (lb) begin
         s_on = 1'b0; spi_miso = ~tb[0];
      end else begin
         spi_miso = cpha ? 1'b0 : seq_bit(sb, 0, lsb);
         s_on = 1'b1;
      end
      wr(3'd3, 8'h01);
      reg_addr = 3'd4;
      n = 0; prev_rdy = 1'b0; last_rdy = 1'b0;
      forever begin
         #1;
         if (!reg_rdata[1] || n > 40000) break;
         n++;
         prev_rdy = last_rdy;
         last_rdy = reg_rdata[0];
         if (poke && n == 5) begin
            reg_addr = 3'd3; reg_wdata = 8'h01; reg_wr = 1'b1;
         end
         @(negedge clk);
         reg_wr = 1'b0; reg_addr = 3'd4;
      end
      if (poke) chk("R11 busy length unchanged by restart", n, busy_len(d));
      else      chk("R6 busy length", n, busy_len(d));
      chk("R7 ready in last busy cycle", {prev_rdy, last_rdy}, 2'b01);
      chk("R8 irq after completion", irq, 1'b1);
      chk("R5 idle level after completion", spi_sck, cpol);
      s_on = 1'b0;
      rd(3'd1, v);
      if (lb) chk("R9 loopback byte", v, tb);
      else begin
         chk("R3/R4 received byte", v, sb);
         chk("R3/R4 byte seen by slave", s_rx, tb);
      end
      #1 chk("R8 irq cleared by read", irq, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1 chk("R1 sck low", spi_sck, 1'b0);
      chk("R1 mosi low", spi_mosi, 1'b0);
      chk("R1 irq low", irq, 1'b0);
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk("R1 register zero", v, 8'h00);
      end
      // R2 register map
      wr(3'd0, 8'hF7); rd(3'd0, v); chk("R2 mode readback", v, 8'h17);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'hA5); rd(3'd2, v); chk("R2 txd readback", v, 8'hA5);
      wr(3'd6, 8'h3C); rd(3'd6, v); chk("R2 divisor readback", v, 8'h3C);
      rd(3'd3, v); chk("R2 control reads zero", v, 8'h00);
      wr(3'd5, 8'hFF); rd(3'd5, v); chk("R2 reserved reads zero", v, 8'h00);
      // R10 disabled port ignores start
      wr(3'd6, 8'h00);
      wr(3'd2, 8'hFF);
      wr(3'd0, 8'h12);
      wr(3'd3, 8'h01);
      reg_addr = 3'd4;
      for (int k = 0; k < 12; k++) begin
         #1 chk("R10 no busy while disabled", reg_rdata, 8'h00);
         chk("R10 sck idle high while disabled", spi_sck, 1'b1);
         chk("R10 mosi low while disabled", spi_mosi, 1'b0);
         @(negedge clk);
      end
      chk("R10 no interrupt while disabled", irq, 1'b0);
      // directed exchanges
      xfer(1'b0, 1'b0, 1'b0, 1'b0, 0,   8'h96, 8'h3A, 1'b0);
      xfer(1'b1, 1'b0, 1'b1, 1'b0, 1,   8'h81, 8'h7E, 1'b0);
      xfer(1'b0, 1'b1, 1'b1, 1'b0, 2,   8'h01, 8'h80, 1'b0);
      xfer(1'b1, 1'b1, 1'b0, 1'b0, 0,   8'hC4, 8'h2B, 1'b0);
      xfer(1'b0, 1'b0, 1'b0, 1'b1, 0,   8'h5C, 8'h00, 1'b0);
      xfer(1'b1, 1'b0, 1'b1, 1'b0, 1,   8'hE1, 8'h1E, 1'b1);
      xfer(1'b0, 1'b0, 1'b0, 1'b0, 255, 8'hB3, 8'h4D, 1'b0);
      // random exchanges
      for (int i = 0; i < 16; i++) begin
         xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
              1'($urandom % 4 == 0), int'($urandom % 4),
              8'($urandom), 8'($urandom), 1'b0);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule